// File: doc/BRIEF.md
# CAN Bus-Off Recovery and Bus-Lock Mode Controller

This block holds the operating mode of a CAN protocol controller and decides how the controller leaves the bus-off state. The error-counter logic reports bus-off entry with a one-cycle event. While the controller is bus off and in operation mode, the block watches the sampled bus bits for the recovery sequence. A two-bit policy input chooses whether and when the controller drops into halt mode around a bus-off episode. Sticky flags record bus-off entry and normal recovery, and software clears them.

The same bit stream feeds a bus-lock detector. It raises a flag when the bus has been held dominant for a long run of bits while the controller is operating. As long as the lock persists, no path may move the controller into halt mode. A reset request still takes effect. Once the flag has been cleared, the detector re-arms only under defined conditions, so a bus that stays stuck does not raise the flag again and again.

Top module: `canbo_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 01 (reset mode) and all three flags are 0. The mode encoding is 00 operation, 01 reset and 10 halt. `req_reset` has the highest priority. `req_halt` acts only from operation mode and is ignored in reset mode. `req_oper` leaves reset or halt mode for operation mode.
- R2: A `busoff_evt` in operation mode, when the controller is not already bus off, sets `flg_busoff` (flag index 0) on the next clock edge.
- R3: With policy 00, recovery completes on the strobe that ends the 128th run of 11 consecutive recessive bits (`bus_bit`=1) sampled in operation mode. That strobe sets `flg_recov` (flag index 1), and the mode stays at operation.
- R4: With policy 01, bus-off entry moves the mode to halt on the same edge that sets `flg_busoff`. No recovery sequence is counted while halted.
- R5: With policy 10, the mode moves to halt on the edge where recovery completes, together with `flg_recov`.
- R6: With policy 11, bus off never leads to halt by itself. A `req_halt` during the bus-off period moves the mode to halt.
- R7: A dominant bit inside a recessive run restarts that run. Recovery does not complete before the full count of runs.
- R8: `flg_lock` (flag index 2) sets on the 32nd consecutive dominant strobe sampled in operation mode. Dominant bits sampled in reset mode never set it.
- R9: After `flg_lock` is cleared, a further run of dominant bits sets it again only after a recessive bit has been seen, or after the mode has passed through reset mode and back into operation.
- R10: While the bus is locked dominant, `req_halt` leaves the mode at operation and `req_reset` still moves it to reset mode.
- R11: A write with `clr_wr`=1 clears each flag whose bit in `clr_data` is 0 and leaves flags whose bit is 1 unchanged. When a set event and a clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid sampled bus bit |
| bus_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| busoff_evt | input | 1 | Bus-off event from the error counters |
| halt_policy | input | 2 | Bus-off to halt policy selector |
| req_oper | input | 1 | Request for operation mode |
| req_reset | input | 1 | Request for reset mode |
| req_halt | input | 1 | Request for halt mode |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_data | input | 3 | Clear write data, 0 bits clear the flag |
| mode | output | 2 | Current mode |
| flg_busoff | output | 1 | Became-bus-off sticky flag |
| flg_recov | output | 1 | Recovered-from-bus-off sticky flag |
| flg_lock | output | 1 | Bus-lock sticky flag |

## Verification
The embedded properties check these rules on every cycle: a reset request always wins, halt is never entered while the dominant counter is saturated, the lock flag only rises out of operation mode, the policy-driven moves into halt, the bound on the recovery run counter, and set priority in each flag. Only the bench's scenarios can show the exact bit counts. These include the 1408th recessive strobe completing recovery and the 1407th not, the restart of a run after a dominant bit, the 31st and 32nd dominant strobes, and the two re-arm paths of the lock detector, which need long histories of stimulus.

// File: rtl/canbo_pkg.sv
package canbo_pkg;
   typedef enum logic [1:0] {
      MODE_OPER  = 2'd0,
      MODE_RESET = 2'd1,
      MODE_HALT  = 2'd2
   } mode_e;

   typedef enum logic [1:0] {
      POL_STD           = 2'd0,
      POL_HALT_AT_OFF   = 2'd1,
      POL_HALT_AT_RECOV = 2'd2,
      POL_HALT_BY_REQ   = 2'd3
   } halt_pol_e;

   localparam int FLAG_BUSOFF = 0;
   localparam int FLAG_RECOV  = 1;
   localparam int FLAG_LOCK   = 2;
   localparam int NUM_FLAGS   = 3;
endpackage

// File: rtl/canbo_sticky_flag.sv
module canbo_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R11: set wins over a simultaneous clear
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
   // R11: flag holds when untouched
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !set && !clr) |=> q);
endmodule

// File: rtl/canbo_lock_det.sv
module canbo_lock_det #(
   parameter int LOCK_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic bus_bit,
   input  logic in_oper,
   input  logic in_reset,
   input  logic flag_q,
   output logic lock_set,
   output logic bus_locked
);
   localparam int CW = $clog2(LOCK_LEN + 1);
   localparam logic [CW-1:0] FULL = CW'(LOCK_LEN);
   localparam logic [CW-1:0] LAST = CW'(LOCK_LEN - 1);

   generate
      if (LOCK_LEN < 2) begin : g_bad_len
         $error("canbo_lock_det: LOCK_LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] dom_cnt;
   logic          armed;

   always_ff @(posedge clk) begin
      if (!rst_n)        dom_cnt <= '0;
      else if (!in_oper) dom_cnt <= '0;
      else if (bit_stb) begin
         if (bus_bit)              dom_cnt <= '0;
         else if (dom_cnt != FULL) dom_cnt <= dom_cnt + 1'b1;
      end
   end

   assign bus_locked = (dom_cnt == FULL);
   assign lock_set   = armed && in_oper && bit_stb && !bus_bit && (dom_cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)        armed <= 1'b1;
      else if (lock_set) armed <= 1'b0;
      else if (in_reset || (!flag_q && bit_stb && bus_bit)) armed <= 1'b1;
   end

   // R8: saturated count stays locked under further dominant bits
   p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_locked && in_oper && bit_stb && !bus_bit) |=> bus_locked);
   // R9: a recessive bit always breaks the lock
   p_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && bus_bit) |=> !bus_locked);
endmodule

// File: rtl/canbo_recov_cnt.sv
module canbo_recov_cnt #(
   parameter int RUN_LEN = 11,
   parameter int SEQ_CNT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic clear,
   input  logic bit_stb,
   input  logic bus_bit,
   output logic done
);
   localparam int RW = $clog2(RUN_LEN);
   localparam int SW = $clog2(SEQ_CNT);
   localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
   localparam logic [SW-1:0] SEQ_LAST = SW'(SEQ_CNT - 1);

   generate
      if (RUN_LEN < 2 || SEQ_CNT < 2) begin : g_bad_cfg
         $error("canbo_recov_cnt: RUN_LEN and SEQ_CNT must be at least 2");
      end
   endgenerate

   logic [RW-1:0] run_q;
   logic [SW-1:0] seq_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         run_q <= '0;
         seq_q <= '0;
      end else if (active && bit_stb) begin
         if (!bus_bit) run_q <= '0;
         else if (run_q == RUN_LAST) begin
            run_q <= '0;
            seq_q <= seq_q + 1'b1;
         end else run_q <= run_q + 1'b1;
      end
   end

   assign done = active && bit_stb && bus_bit && (run_q == RUN_LAST) && (seq_q == SEQ_LAST);

   // R7: run counter stays inside its range
   p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_LAST);
   // R7: a dominant bit restarts the run
   p_run_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !clear && bit_stb && !bus_bit) |=> (run_q == '0));
endmodule

// File: rtl/canbo_mode_ctrl.sv
module canbo_mode_ctrl
   import canbo_pkg::*;
#(
   parameter int LOCK_LEN = 32,
   parameter int RUN_LEN  = 11,
   parameter int SEQ_CNT  = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_stb,
   input  logic       bus_bit,
   input  logic       busoff_evt,
   input  logic [1:0] halt_policy,
   input  logic       req_oper,
   input  logic       req_reset,
   input  logic       req_halt,
   input  logic       clr_wr,
   input  logic [2:0] clr_data,
   output logic [1:0] mode,
   output logic       flg_busoff,
   output logic       flg_recov,
   output logic       flg_lock
);
   mode_e mode_q, mode_d;
   logic  busoff_st;
   logic  in_oper, in_reset;
   logic  busoff_entry, recov_done;
   logic  lock_set, bus_locked;
   logic  [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

   assign in_oper      = (mode_q == MODE_OPER);
   assign in_reset     = (mode_q == MODE_RESET);
   assign busoff_entry = busoff_evt && in_oper && !busoff_st;

   canbo_lock_det #(.LOCK_LEN(LOCK_LEN)) u_lock (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bus_bit(bus_bit),
      .in_oper(in_oper), .in_reset(in_reset), .flag_q(flag_q[FLAG_LOCK]),
      .lock_set(lock_set), .bus_locked(bus_locked)
   );

   canbo_recov_cnt #(.RUN_LEN(RUN_LEN), .SEQ_CNT(SEQ_CNT)) u_recov (
      .clk(clk), .rst_n(rst_n), .active(busoff_st && in_oper),
      .clear(!busoff_st), .bit_stb(bit_stb), .bus_bit(bus_bit),
      .done(recov_done)
   );

   always_comb begin
      mode_d = mode_q;
      if (req_reset) mode_d = MODE_RESET;
      else if (in_oper) begin
         if (!bus_locked &&
             ((busoff_entry && halt_policy == POL_HALT_AT_OFF) ||
              (recov_done   && halt_policy == POL_HALT_AT_RECOV) ||
              req_halt))
            mode_d = MODE_HALT;
      end else if (req_oper) mode_d = MODE_OPER;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= MODE_RESET;
      else        mode_q <= mode_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || in_reset) busoff_st <= 1'b0;
      else if (busoff_entry)  busoff_st <= 1'b1;
      else if (recov_done)    busoff_st <= 1'b0;
   end

   assign flag_set[FLAG_BUSOFF] = busoff_entry;
   assign flag_set[FLAG_RECOV]  = recov_done;
   assign flag_set[FLAG_LOCK]   = lock_set;
   assign flag_clr = {NUM_FLAGS{clr_wr}} & ~clr_data;

   generate
      for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         canbo_sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(flag_set[gi]),
            .clr(flag_clr[gi]), .q(flag_q[gi])
         );
      end
   endgenerate

   assign mode       = mode_q;
   assign flg_busoff = flag_q[FLAG_BUSOFF];
   assign flg_recov  = flag_q[FLAG_RECOV];
   assign flg_lock   = flag_q[FLAG_LOCK];

   p_reset_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_reset |=> (mode == MODE_RESET));
   p_halt_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_locked && !req_reset) |=> (mode != MODE_HALT));
   p_pol_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busoff_entry && halt_policy == POL_HALT_AT_OFF && !bus_locked && !req_reset)
      |=> (mode == MODE_HALT));
   p_pol_recov_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (recov_done && halt_policy == POL_HALT_AT_RECOV && !req_reset)
      |=> (mode == MODE_HALT && !busoff_st));
   p_pol_std_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (recov_done && halt_policy == POL_STD && !req_reset && !req_halt)
      |=> (mode == MODE_OPER && flg_recov));
   p_lock_oper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_lock) |-> ($past(mode) == MODE_OPER));
   p_busoff_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busoff_entry |=> (flg_busoff && busoff_st));
endmodule

// File: tb/canbo_mode_ctrl_tb.sv
module canbo_mode_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_stb = 1'b0, bus_bit = 1'b1, busoff_evt = 1'b0;
   logic [1:0] halt_policy = 2'd0;
   logic       req_oper = 1'b0, req_reset = 1'b0, req_halt = 1'b0;
   logic       clr_wr = 1'b0;
   logic [2:0] clr_data = 3'b111;
   logic [1:0] mode;
   logic       flg_busoff, flg_recov, flg_lock;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   localparam logic [1:0] M_OPER = 2'd0, M_RST = 2'd1, M_HALT = 2'd2;
   localparam int RECOV_BITS = 128 * 11;

   // {policy[6:5], mode after entry[4:3], mode after recovery bits[2:1], recov flag[0]}
   localparam logic [6:0] VEC [0:3] = '{
      7'b00_00_00_1, 7'b01_10_10_0, 7'b10_00_10_1, 7'b11_00_00_1
   };

   always #4 clk = ~clk;

   canbo_mode_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bus_bit(bus_bit),
      .busoff_evt(busoff_evt), .halt_policy(halt_policy), .req_oper(req_oper),
      .req_reset(req_reset), .req_halt(req_halt), .clr_wr(clr_wr),
      .clr_data(clr_data), .mode(mode), .flg_busoff(flg_busoff),
      .flg_recov(flg_recov), .flg_lock(flg_lock)
   );

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic strb(input logic b, input int n);
      for (int i = 0; i < n; i++) begin
         bus_bit = b; bit_stb = 1'b1;
         @(negedge clk);
      end
      bit_stb = 1'b0; bus_bit = 1'b1;
   endtask

   task automatic go_oper();  req_oper = 1;  @(negedge clk); req_oper = 0;  endtask
   task automatic go_reset(); req_reset = 1; @(negedge clk); req_reset = 0; endtask
   task automatic go_halt();  req_halt = 1;  @(negedge clk); req_halt = 0;  endtask
   task automatic bus_off();  busoff_evt = 1; @(negedge clk); busoff_evt = 0; endtask
   task automatic clear(input logic [2:0] d);
      clr_wr = 1; clr_data = d; @(negedge clk); clr_wr = 0; clr_data = 3'b111;
   endtask

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      chk("R1 mode", mode, M_RST);
      chk("R1 flags", {1'b0, flg_lock, flg_recov, flg_busoff}, 4'd0);
      go_halt();
      chk("R1 halt ignored in reset", mode, M_RST);

      // policy table
      for (int v = 0; v < 4; v++) begin
         string tg;
         logic [6:0] e;
         e = VEC[v];
         tg = (v == 0) ? "R3" : (v == 1) ? "R4" : (v == 2) ? "R5" : "R6";
         do_reset();
         halt_policy = e[6:5];
         go_oper();
         chk("R1 oper", mode, M_OPER);
         bus_off();
         chk("R2 busoff flag", flg_busoff, 1);
         chk({tg, " entry mode"}, mode, e[4:3]);
         strb(1'b1, RECOV_BITS - 1);
         chk("R7 no early recovery", flg_recov, 0);
         strb(1'b1, 1);
         chk({tg, " recov flag"}, flg_recov, e[0]);
         chk({tg, " final mode"}, mode, e[2:1]);
      end

      // R6 halt request during bus off
      do_reset(); halt_policy = 2'd3; go_oper(); bus_off();
      strb(1'b1, 100);
      go_halt();
      chk("R6 halt on request", mode, M_HALT);
      chk("R6 no recovery", flg_recov, 0);

      // R7 interrupted run
      do_reset(); halt_policy = 2'd0; go_oper(); bus_off();
      strb(1'b1, 127 * 11);
      strb(1'b1, 10); strb(1'b0, 1); strb(1'b1, 10);
      chk("R7 run restarted", flg_recov, 0);
      strb(1'b1, 1);
      chk("R7 recovery after full run", flg_recov, 1);

      // R8 lock threshold
      do_reset();
      strb(1'b0, 40);
      chk("R8 no lock in reset mode", flg_lock, 0);
      go_oper();
      strb(1'b0, 31);
      chk("R8 31 dominant", flg_lock, 0);
      strb(1'b0, 1);
      chk("R8 32 dominant", flg_lock, 1);

      // R10 halt blocked while locked, reset honoured
      go_halt();
      chk("R10 halt blocked", mode, M_OPER);

      // R9 re-arm by recessive bit
      clear(3'b011);
      chk("R11 lock cleared", flg_lock, 0);
      strb(1'b0, 40);
      chk("R9 no re-set without recessive", flg_lock, 0);
      strb(1'b1, 1);
      strb(1'b0, 32);
      chk("R9 re-set after recessive", flg_lock, 1);

      // R9 re-arm through reset mode
      strb(1'b0, 5);
      clear(3'b011);
      go_reset();
      chk("R10 reset while locked", mode, M_RST);
      go_oper();
      strb(1'b0, 32);
      chk("R9 re-set after reset pass", flg_lock, 1);

      // R11 clear and set priority
      do_reset(); go_oper();
      clr_wr = 1; clr_data = 3'b110; busoff_evt = 1;
      @(negedge clk);
      clr_wr = 0; clr_data = 3'b111; busoff_evt = 0;
      chk("R11 set wins", flg_busoff, 1);
      clear(3'b111);
      chk("R11 one bits keep", flg_busoff, 1);
      clear(3'b110);
      chk("R11 zero bit clears", flg_busoff, 0);

      // R1 halt to oper
      go_halt();
      chk("R1 halt from oper", mode, M_HALT);
      go_oper();
      chk("R1 oper from halt", mode, M_OPER);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule